// File: doc/BRIEF.md
# Static LCD Seven-Segment Display Driver

This block drives a static (non-multiplexed) liquid crystal panel that shows a signed reading of three and a half digits. It receives a finished result as three BCD digits (hundreds, tens, units), a bit for the leading half digit and a sign bit. These values are captured only when a strobe is pulsed, so the panel holds steady while the next result is being produced. Each full digit is decoded into seven segment drives. The half digit has one drive, which lights the whole "1". The minus sign has one drive.

Every segment is driven with an AC waveform. A square-wave backplane is made by dividing the input clock. A segment that should be dark is driven in phase with the backplane. A segment that should be lit is driven in antiphase, so the average voltage across the glass is zero.

The backplane comes from a two-state machine with the states `BP_LOW` and `BP_HIGH`. A counter runs through `HALF_DIV` clocks. On the terminal count, the transition `BP_LOW -> BP_HIGH` or `BP_HIGH -> BP_LOW` is taken. Otherwise the machine stays in its state. With the default of 400, the backplane period is 800 clocks.

A lamp-test input overrides everything and shows -1888 with a constant (DC) pattern. The backplane counter keeps running underneath it.

Top module: `lcd_static_drv`

## Requirements
- R1: The backplane output toggles exactly every `HALF_DIV` (default 400) clocks while lamp test is low, giving a period of 2*`HALF_DIV` clocks with 50 percent duty.
- R2: A dark segment's drive equals the backplane level; a lit segment's drive is its inverse.
- R3: A full digit holding BCD 0 to 9 lights segments per the usual seven-segment font. Bit 0 is segment a, through bit 6 for segment g, so the patterns (lit=1) are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F hex.
- R4: A full digit holding BCD 10 to 15 shows no lit segments.
- R5: The half-digit drive is lit when the latched half-digit bit is 1 and dark when it is 0.
- R6: The minus drive is lit when the latched sign bit is 1 (negative) and dark when it is 0.
- R7: While lamp test is high, the backplane is driven 0 and every segment, the half digit and the minus drive are driven 1 (a constant -1888). When lamp test is released, alternation resumes in the phase the free-running divider has reached.
- R8: Reading inputs are captured only on a clock edge where `latch_stb` is 1; changes at any other time leave the display unchanged.
- R9: All drives and the backplane are registered together. A strobe at edge k appears at the outputs from edge k+1, and a backplane state change appears on the same edge as the matching segment inversion.
- R10: While reset is low, every output is 0. After reset, the latched reading is blank (digits 15, half digit 0, sign 0), so nothing is lit until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latch_stb | input | 1 | Capture the reading inputs at this edge |
| units_bcd | input | 4 | Units digit, BCD |
| tens_bcd | input | 4 | Tens digit, BCD |
| hund_bcd | input | 4 | Hundreds digit, BCD |
| half_one | input | 1 | Leading half digit shows "1" |
| negative | input | 1 | Reading is negative |
| lamp_test | input | 1 | Force all drives on, DC |
| backplane | output | 1 | Backplane square wave |
| units_seg | output | 7 | Units segment drives, bit 0 = a .. bit 6 = g |
| tens_seg | output | 7 | Tens segment drives |
| hund_seg | output | 7 | Hundreds segment drives |
| half_seg | output | 1 | Half-digit drive |
| minus_seg | output | 1 | Minus sign drive |

## Verification
Two cases can fall on the same clock edge. In the first, a capture strobe lands on the edge where the divider takes its terminal-count transition. The bench provokes it by watching its own model counter and raising the strobe on the cycle before the wrap. The new digits must then appear already inverted for the new backplane level on one edge, with no intermediate pattern. In the second, lamp test and a strobe coincide. The capture must still happen, and it must become visible, in the correct phase, on release. A behavioural model is compared with every output on every cycle to judge both cases.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    localparam int SEG_W = 7;
    localparam int BCD_W = 4;

    localparam logic [BCD_W-1:0] BCD_BLANK = 4'hF;

    typedef enum logic {
        BP_LOW  = 1'b0,
        BP_HIGH = 1'b1
    } bp_phase_e;

    typedef struct packed {
        logic [BCD_W-1:0] hund;
        logic [BCD_W-1:0] tens;
        logic [BCD_W-1:0] units;
        logic             half_one;
        logic             negative;
    } reading_t;

    localparam reading_t READING_BLANK = '{
        hund:     BCD_BLANK,
        tens:     BCD_BLANK,
        units:    BCD_BLANK,
        half_one: 1'b0,
        negative: 1'b0
    };

    // Lit-segment pattern, bit 0 = a ... bit 6 = g; codes above 9 are dark.
    function automatic logic [SEG_W-1:0] bcd_to_seg(input logic [BCD_W-1:0] v);
        logic [SEG_W-1:0] s;
        case (v)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lcd_bp_phase.sv
module lcd_bp_phase
    import lcd_drv_pkg::*;
#(
    parameter int HALF_DIV = 400
) (
    input  logic      clk,
    input  logic      rst_n,
    output bp_phase_e phase_o
);

    localparam int              CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    bp_phase_e        state_q;
    bp_phase_e        state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == LAST);

    // Dwell counter inside the current phase.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BP_LOW:  if (wrap) state_d = BP_HIGH;
            BP_HIGH: if (wrap) state_d = BP_LOW;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BP_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    assign phase_o = state_q;

    // R1
    phase_wrap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> ($past(cnt_q) == LAST));

    // R1
    wrap_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (state_q != $past(state_q)));

endmodule

// File: rtl/lcd_reading_latch.sv
module lcd_reading_latch
    import lcd_drv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stb_i,
    input  reading_t d_i,
    output reading_t q_o
);

    reading_t q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= READING_BLANK;
        end else if (stb_i) begin
            q_r <= d_i;
        end
    end

    assign q_o = q_r;

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(q_r));

    // R8
    capture_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> (q_r == $past(d_i)));

endmodule

// File: rtl/lcd_seg_decode.sv
module lcd_seg_decode
    import lcd_drv_pkg::*;
#(
    parameter int N_DIG = 3
) (
    input  logic [N_DIG*BCD_W-1:0] bcd_i,
    output logic [N_DIG*SEG_W-1:0] seg_o
);

    for (genvar g = 0; g < N_DIG; g++) begin : g_dig
        assign seg_o[g*SEG_W +: SEG_W] = bcd_to_seg(bcd_i[g*BCD_W +: BCD_W]);
    end

endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv
    import lcd_drv_pkg::*;
#(
    parameter int HALF_DIV = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       latch_stb,
    input  logic [3:0] units_bcd,
    input  logic [3:0] tens_bcd,
    input  logic [3:0] hund_bcd,
    input  logic       half_one,
    input  logic       negative,
    input  logic       lamp_test,
    output logic       backplane,
    output logic [6:0] units_seg,
    output logic [6:0] tens_seg,
    output logic [6:0] hund_seg,
    output logic       half_seg,
    output logic       minus_seg
);

    localparam int N_DIG = 3;

    bp_phase_e              phase;
    reading_t               rd_in;
    reading_t               rd_q;
    logic [N_DIG*SEG_W-1:0] lit;
    logic                   ph_hi;

    assign rd_in = '{
        hund:     hund_bcd,
        tens:     tens_bcd,
        units:    units_bcd,
        half_one: half_one,
        negative: negative
    };

    lcd_bp_phase #(
        .HALF_DIV (HALF_DIV)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    lcd_reading_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_i (latch_stb),
        .d_i   (rd_in),
        .q_o   (rd_q)
    );

    lcd_seg_decode #(
        .N_DIG (N_DIG)
    ) u_dec (
        .bcd_i ({rd_q.hund, rd_q.tens, rd_q.units}),
        .seg_o (lit)
    );

    assign ph_hi = (phase == BP_HIGH);

    // Output register: backplane and every drive move on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            backplane <= 1'b0;
            units_seg <= '0;
            tens_seg  <= '0;
            hund_seg  <= '0;
            half_seg  <= 1'b0;
            minus_seg <= 1'b0;
        end else if (lamp_test) begin
            backplane <= 1'b0;
            units_seg <= '1;
            tens_seg  <= '1;
            hund_seg  <= '1;
            half_seg  <= 1'b1;
            minus_seg <= 1'b1;
        end else begin
            backplane <= ph_hi;
            units_seg <= lit[0*SEG_W +: SEG_W] ^ {SEG_W{ph_hi}};
            tens_seg  <= lit[1*SEG_W +: SEG_W] ^ {SEG_W{ph_hi}};
            hund_seg  <= lit[2*SEG_W +: SEG_W] ^ {SEG_W{ph_hi}};
            half_seg  <= rd_q.half_one ^ ph_hi;
            minus_seg <= rd_q.negative ^ ph_hi;
        end
    end

    // R7
    lamp_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_test |=> (!backplane && (units_seg == 7'h7F) && (tens_seg == 7'h7F)
                       && (hund_seg == 7'h7F) && half_seg && minus_seg));

    // R6
    minus_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lamp_test && !rd_q.negative) |=> (minus_seg == backplane));

    // R5
    half_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lamp_test && rd_q.half_one) |=> (half_seg != backplane));

    // R9
    bp_follows_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lamp_test |=> (backplane == $past(ph_hi)));

endmodule

// File: tb/lcd_static_drv_bench.sv
module lcd_static_drv_bench;

    localparam int HALF_DIV = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       latch_stb = 1'b0;
    logic [3:0] units_bcd = 4'd0;
    logic [3:0] tens_bcd = 4'd0;
    logic [3:0] hund_bcd = 4'd0;
    logic       half_one = 1'b0;
    logic       negative = 1'b0;
    logic       lamp_test = 1'b0;
    logic       backplane;
    logic [6:0] units_seg, tens_seg, hund_seg;
    logic       half_seg, minus_seg;

    lcd_static_drv #(.HALF_DIV(HALF_DIV)) u_lcd_static_drv (
        .clk(clk), .rst_n(rst_n), .latch_stb(latch_stb),
        .units_bcd(units_bcd), .tens_bcd(tens_bcd), .hund_bcd(hund_bcd),
        .half_one(half_one), .negative(negative), .lamp_test(lamp_test),
        .backplane(backplane), .units_seg(units_seg), .tens_seg(tens_seg),
        .hund_seg(hund_seg), .half_seg(half_seg), .minus_seg(minus_seg)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Font written as lit-segment letters, bit 0 = a.
    function automatic logic [6:0] glyph(input int d);
        string s;
        logic [6:0] r = '0;
        case (d)
            0: s = "abcdef";
            1: s = "bc";
            2: s = "abdeg";
            3: s = "abcdg";
            4: s = "bcfg";
            5: s = "acdfg";
            6: s = "acdefg";
            7: s = "abc";
            8: s = "abcdefg";
            9: s = "abcdfg";
            default: s = "";
        endcase
        for (int i = 0; i < s.len(); i++) r[int'(s[i]) - 97] = 1'b1;
        return r;
    endfunction

    // Behavioural model, advanced on each rising edge.
    int   m_cnt = 0;
    bit   m_ph = 1'b0;
    int   m_u = 15, m_t = 15, m_h = 15;
    bit   m_half = 1'b0, m_neg = 1'b0;
    logic e_bp = 1'b0, e_half = 1'b0, e_min = 1'b0;
    logic [6:0] e_u = '0, e_t = '0, e_h = '0;
    bit   live = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ph = 1'b0;
            m_u = 15; m_t = 15; m_h = 15; m_half = 1'b0; m_neg = 1'b0;
            e_bp = 1'b0; e_u = '0; e_t = '0; e_h = '0; e_half = 1'b0; e_min = 1'b0;
        end else begin
            if (lamp_test) begin
                e_bp = 1'b0; e_u = '1; e_t = '1; e_h = '1; e_half = 1'b1; e_min = 1'b1;
            end else begin
                e_bp   = m_ph;
                e_u    = glyph(m_u) ^ {7{m_ph}};
                e_t    = glyph(m_t) ^ {7{m_ph}};
                e_h    = glyph(m_h) ^ {7{m_ph}};
                e_half = m_half ^ m_ph;
                e_min  = m_neg ^ m_ph;
            end
            if (latch_stb) begin
                m_u = int'(units_bcd); m_t = int'(tens_bcd); m_h = int'(hund_bcd);
                m_half = half_one; m_neg = negative;
            end
            m_cnt++;
            if (m_cnt == HALF_DIV) begin
                m_cnt = 0;
                m_ph = ~m_ph;
            end
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (live && !done) begin
            check(backplane == e_bp, "R1 R9 backplane", 32'(backplane), 32'(e_bp));
            check(units_seg == e_u, "R2 R3 units", 32'(units_seg), 32'(e_u));
            check(tens_seg == e_t, "R2 R3 tens", 32'(tens_seg), 32'(e_t));
            check(hund_seg == e_h, "R2 R3 hundreds", 32'(hund_seg), 32'(e_h));
            check(half_seg == e_half, "R5 half", 32'(half_seg), 32'(e_half));
            check(minus_seg == e_min, "R6 minus", 32'(minus_seg), 32'(e_min));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input int h, input int t, input int u, input bit hf, input bit ng);
        hund_bcd = 4'(h); tens_bcd = 4'(t); units_bcd = 4'(u);
        half_one = hf; negative = ng; latch_stb = 1'b1;
        @(negedge clk);
        latch_stb = 1'b0;
    endtask

    function automatic logic [6:0] shown(input int d);
        return glyph(d) ^ {7{backplane}};
    endfunction

    task automatic summary();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int t0;
        cyc(3);
        // R10 reset state
        check({backplane, units_seg, tens_seg, hund_seg, half_seg, minus_seg} == '0,
              "R10 reset outputs", 32'({units_seg, tens_seg, hund_seg}), 0);
        rst_n = 1'b1;
        live  = 1'b1;
        cyc(3);
        check(units_seg == {7{backplane}} && minus_seg == backplane, "R10 blank after reset",
              32'(units_seg), 32'({7{backplane}}));

        // R9: strobe visible one edge later
        hund_bcd = 4'd1; tens_bcd = 4'd2; units_bcd = 4'd7; latch_stb = 1'b1;
        @(negedge clk);
        latch_stb = 1'b0;
        check(units_seg == {7{backplane}}, "R9 old value right after strobe edge",
              32'(units_seg), 32'({7{backplane}}));
        @(negedge clk);
        check(units_seg == shown(7), "R9 new value one edge later", 32'(units_seg), 32'(shown(7)));

        // R1 period: rise to fall and fall to rise
        while (backplane !== 1'b0) @(negedge clk);
        while (backplane !== 1'b1) @(negedge clk);
        t0 = 0;
        while (backplane === 1'b1) begin @(negedge clk); t0++; end
        check(t0 == HALF_DIV, "R1 high time", 32'(t0), 32'(HALF_DIV));
        t0 = 0;
        while (backplane === 1'b0) begin @(negedge clk); t0++; end
        check(t0 == HALF_DIV, "R1 low time", 32'(t0), 32'(HALF_DIV));

        // R8: inputs move without strobe
        hund_bcd = 4'd9; tens_bcd = 4'd9; units_bcd = 4'd9; negative = 1'b1; half_one = 1'b1;
        cyc(50);
        check(units_seg == shown(7) && tens_seg == shown(2), "R8 ignored without strobe",
              32'({tens_seg, units_seg}), 32'({shown(2), shown(7)}));
        check(minus_seg == backplane, "R8 sign ignored without strobe", 32'(minus_seg), 32'(backplane));

        // R3 and R2 over all decimal digits
        for (int d = 0; d < 10; d++) begin
            load(d, (d + 3) % 10, 9 - d, 1'b0, 1'b0);
            @(negedge clk);
            check(hund_seg == shown(d), "R3 hundreds digit", 32'(hund_seg), 32'(shown(d)));
            check(units_seg == shown(9 - d), "R3 units digit", 32'(units_seg), 32'(shown(9 - d)));
        end
        load(8, 8, 8, 1'b0, 1'b0);
        @(negedge clk);
        check(units_seg == ~{7{backplane}}, "R2 lit segments are antiphase",
              32'(units_seg), 32'(~{7{backplane}}));

        // R4 codes 10..15 are dark
        for (int c = 10; c < 16; c++) begin
            load(c, c, c, 1'b0, 1'b0);
            @(negedge clk);
            check(units_seg == {7{backplane}} && hund_seg == {7{backplane}}, "R4 invalid code dark",
                  32'(units_seg), 32'({7{backplane}}));
        end

        // R5 and R6
        load(1, 0, 5, 1'b1, 1'b1);
        @(negedge clk);
        check(half_seg != backplane, "R5 half lit", 32'(half_seg), 32'(~backplane));
        check(minus_seg != backplane, "R6 minus lit", 32'(minus_seg), 32'(~backplane));
        load(1, 0, 5, 1'b0, 1'b0);
        @(negedge clk);
        check(half_seg == backplane, "R5 half dark", 32'(half_seg), 32'(backplane));
        check(minus_seg == backplane, "R6 minus dark", 32'(minus_seg), 32'(backplane));

        // R7 lamp test across a divider wrap, with a strobe in the same cycle
        lamp_test = 1'b1;
        hund_bcd = 4'd4; tens_bcd = 4'd5; units_bcd = 4'd6; half_one = 1'b1; negative = 1'b0;
        latch_stb = 1'b1;
        @(negedge clk);
        latch_stb = 1'b0;
        for (int k = 0; k < 5; k++) begin
            check(!backplane && units_seg == 7'h7F && tens_seg == 7'h7F && hund_seg == 7'h7F
                  && half_seg && minus_seg, "R7 lamp pattern constant",
                  32'({backplane, units_seg}), 32'({1'b0, 7'h7F}));
            cyc(200);
        end
        lamp_test = 1'b0;
        cyc(2);
        check(units_seg == shown(6) && half_seg != backplane, "R7 capture during lamp shown after",
              32'(units_seg), 32'(shown(6)));

        // Strobe on the divider wrap edge
        while (m_cnt != HALF_DIV - 1) @(negedge clk);
        load(3, 1, 4, 1'b0, 1'b1);
        @(negedge clk);
        check(units_seg == shown(4) && minus_seg != backplane, "R9 strobe on wrap edge",
              32'(units_seg), 32'(shown(4)));

        cyc(900);
        summary();
    end

endmodule